// File: doc/BRIEF.md
# Serial Synthesizer Programming Interface

This block takes a three-wire serial control stream (serial clock, serial data, load strobe) and turns it into the settings used by a frequency synthesizer. The stream runs slower than the block's system clock, so all three lines are brought into the system clock domain through a synchronizer. Each rising edge of the serial clock pushes one data bit into a 19-bit shift register, most significant bit first.

When the load strobe rises, the bit that arrived last (bit 0 of the shift register) chooses which of two holding registers takes the word. A set bit 0 writes the reference-path register: a 14-bit reference divide ratio, a prescaler modulus select, a power-save control and an output monitor select. A clear bit 0 writes the main-path register: a 7-bit swallow count and an 11-bit main counter value. Each register keeps its contents until the next load of its own kind. A one-cycle update strobe marks each write.

Top module: `synth_prog_if`

## Requirements
- R1: Serial data is captured into the 19-bit shift register on each rising edge of `ser_clk`, with bits sent most significant first. Only the last 19 bits shifted in are kept, and the last bit lands in bit 0.
- R2: A rising edge of `ser_le` loads the shift register into the reference register when bit 0 is 1, and into the main register when bit 0 is 0.
- R3: On a reference load, `ref_ratio` takes bits 14..1, the prescaler select takes bit 15, the power-save control takes bit 16 and `mon_sel` takes bit 17. Bit 18 is ignored.
- R4: On a main load, `swallow` takes bits 7..1 and `main_count` takes bits 18..8.
- R5: `presc_mod64` is 1 when the prescaler select bit is 1 (modulus 64/65) and 0 when it is 0 (modulus 128/129). `pwr_save` is 1 when the power-save control bit is 0 and 0 when it is 1.
- R6: Each holding register keeps its value until the next load of its own kind. A load of the other kind leaves it unchanged.
- R7: Every rising edge of `ser_le` produces exactly one single-cycle strobe (`ref_upd` or `main_upd`, never both), however long `ser_le` stays high. The strobe and the new output values appear together on the third rising edge of `clk` after `ser_le` is first high at a rising edge.
- R8: After reset both holding registers are zero: `ref_ratio`, `swallow`, `main_count`, `presc_mod64` and `mon_sel` are 0, `pwr_save` is 1, and both strobes are 0.
- R9: Bits shifted in while `ser_le` stays low change no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ser_clk | input | 1 | Serial bit clock, sampled by `clk` |
| ser_data | input | 1 | Serial data bit |
| ser_le | input | 1 | Load strobe; its rising edge writes a holding register |
| ref_ratio | output | 14 | Reference divide ratio |
| presc_mod64 | output | 1 | 1 selects prescaler modulus 64/65, 0 selects 128/129 |
| pwr_save | output | 1 | 1 requests power saving |
| mon_sel | output | 1 | Output monitor select |
| swallow | output | 7 | Swallow counter value |
| main_count | output | 11 | Main counter value |
| ref_upd | output | 1 | One-cycle strobe on a reference register write |
| main_upd | output | 1 | One-cycle strobe on a main register write |

## Verification
All three serial lines pass through the same two-stage synchronizer and then one edge-detect register. A load strobe is therefore due on the third rising `clk` edge after `ser_le` is first seen high, and the outputs change on that same edge. The driver changes `ser_data` only while `ser_clk` is low and holds each level for three cycles, so the order of the bits survives the synchronizer. Before it raises `ser_le`, the driver queues the full expected state of both registers. The monitor samples on falling edges, pops one queued item for each strobe it sees, compares every output field, and flags any strobe that has no queued item. After a run of bits with no load, the bench waits longer than the pipeline latency before it compares the outputs against the model.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int REF_W     = 14;
  localparam int SWL_W     = 7;
  localparam int CNT_W     = 11;
  localparam int FLAG_W    = 3;
  localparam int WORD_W    = 1 + SWL_W + CNT_W;
  localparam int REFWORD_W = 1 + REF_W + FLAG_W;

  typedef struct packed {
    logic             mon_sel;
    logic             ps;
    logic             sw;
    logic [REF_W-1:0] ratio;
  } ref_cfg_t;

  typedef struct packed {
    logic [CNT_W-1:0] count;
    logic [SWL_W-1:0] swallow;
  } main_cfg_t;
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      always_comb stage_d = din;
    end else begin : g_next
      always_comb stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/ssp_shift.sv
module ssp_shift #(
  parameter int WIDTH = ssp_pkg::WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_s,
  input  logic             sdata_s,
  output logic [WIDTH-1:0] word_q
);
  logic             sclk_p;
  logic             shift_en;
  logic [WIDTH-1:0] word_d;

  always_comb begin
    shift_en = sclk_s & ~sclk_p;
    word_d   = word_q;
    if (shift_en) word_d = {word_q[WIDTH-2:0], sdata_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= 1'b0;
      word_q <= '0;
    end else begin
      sclk_p <= sclk_s;
      word_q <= word_d;
    end
  end

  // a new bit always enters at bit 0 and the older bits move up
  assert_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (word_q[0] == $past(sdata_s)) && (word_q[WIDTH-1:1] == $past(word_q[WIDTH-2:0])));

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(word_q));
endmodule

// File: rtl/ssp_regs.sv
module ssp_regs
  import ssp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word,
  input  logic              le_s,
  output ref_cfg_t          ref_q,
  output main_cfg_t         main_q,
  output logic              ref_upd,
  output logic              main_upd
);
  logic      le_p;
  logic      le_rise;
  logic      wr_ref;
  logic      wr_main;
  ref_cfg_t  ref_d;
  main_cfg_t main_d;

  always_comb begin
    le_rise = le_s & ~le_p;
    wr_ref  = le_rise & word[0];
    wr_main = le_rise & ~word[0];
    ref_d   = ref_q;
    main_d  = main_q;
    if (wr_ref)  ref_d  = ref_cfg_t'(word[REFWORD_W-1:1]);
    if (wr_main) main_d = main_cfg_t'(word[WORD_W-1:1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      le_p     <= 1'b0;
      ref_q    <= '0;
      main_q   <= '0;
      ref_upd  <= 1'b0;
      main_upd <= 1'b0;
    end else begin
      le_p     <= le_s;
      ref_q    <= ref_d;
      main_q   <= main_d;
      ref_upd  <= wr_ref;
      main_upd <= wr_main;
    end
  end

  assert_ref_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ref |=> (ref_q == ref_cfg_t'($past(word[REFWORD_W-1:1]))) && ref_upd);

  assert_main_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_main |=> (main_q == main_cfg_t'($past(word[WORD_W-1:1]))) && main_upd);

  assert_ref_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ref |=> $stable(ref_q) && !ref_upd);

  assert_main_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_main |=> $stable(main_q) && !main_upd);

  assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ref_upd, main_upd}) <= 1);

  assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_upd || main_upd) |=> !(ref_upd || main_upd));
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
  import ssp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_data,
  input  logic             ser_le,
  output logic [REF_W-1:0] ref_ratio,
  output logic             presc_mod64,
  output logic             pwr_save,
  output logic             mon_sel,
  output logic [SWL_W-1:0] swallow,
  output logic [CNT_W-1:0] main_count,
  output logic             ref_upd,
  output logic             main_upd
);
  logic              rst_meta;
  logic              rst_sync_n;
  logic [2:0]        ser_s;
  logic [WORD_W-1:0] word;
  ref_cfg_t          ref_q;
  main_cfg_t         main_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  ssp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .din   ({ser_le, ser_data, ser_clk}),
    .dout  (ser_s)
  );

  ssp_shift #(.WIDTH(WORD_W)) i_shift (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .sclk_s  (ser_s[0]),
    .sdata_s (ser_s[1]),
    .word_q  (word)
  );

  ssp_regs i_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .word     (word),
    .le_s     (ser_s[2]),
    .ref_q    (ref_q),
    .main_q   (main_q),
    .ref_upd  (ref_upd),
    .main_upd (main_upd)
  );

  always_comb begin
    ref_ratio   = ref_q.ratio;
    presc_mod64 = ref_q.sw;
    pwr_save    = ~ref_q.ps;
    mon_sel     = ref_q.mon_sel;
    swallow     = main_q.swallow;
    main_count  = main_q.count;
  end

  // decoded power-save output must mirror the inverted stored control
  assert_psave_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ref_upd |-> (pwr_save != $past(word[16])));
endmodule

// File: tb/test_synth_prog_if.sv
module test_synth_prog_if;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ser_clk, ser_data, ser_le;
  logic [13:0] ref_ratio;
  logic        presc_mod64, pwr_save, mon_sel;
  logic [6:0]  swallow;
  logic [10:0] main_count;
  logic        ref_upd, main_upd;

  typedef struct {
    bit          is_ref;
    logic [13:0] ratio;
    logic        mod64, psave, mon;
    logic [6:0]  swl;
    logic [10:0] cnt;
  } exp_t;

  exp_t exp_q[$];
  exp_t model;
  int   total = 0;
  int   bad   = 0;
  bit   mon_on = 1'b0;
  bit   done   = 1'b0;

  always #10 clk = ~clk;

  synth_prog_if i_synth_prog_if (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
    .ref_ratio(ref_ratio), .presc_mod64(presc_mod64), .pwr_save(pwr_save),
    .mon_sel(mon_sel), .swallow(swallow), .main_count(main_count),
    .ref_upd(ref_upd), .main_upd(main_upd)
  );

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cmp_state(string req, exp_t e);
    chk(req, "ref_ratio",   ref_ratio,   e.ratio);
    chk(req, "presc_mod64", presc_mod64, e.mod64);
    chk(req, "pwr_save",    pwr_save,    e.psave);
    chk(req, "mon_sel",     mon_sel,     e.mon);
    chk(req, "swallow",     swallow,     e.swl);
    chk(req, "main_count",  main_count,  e.cnt);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bit(logic b);
    ser_data = b;
    ser_clk  = 1'b0;
    tick(3);
    ser_clk  = 1'b1;
    tick(3);
    ser_clk  = 1'b0;
  endtask

  task automatic send_bits(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) shift_bit(v[i]);
  endtask

  task automatic pulse_le(int hold);
    tick(2);
    ser_le = 1'b1;
    tick(hold);
    ser_le = 1'b0;
    tick(4);
  endtask

  // R3, R5: reference word layout bit0=1, ratio 14..1, select 15, power 16, monitor 17
  task automatic load_ref(logic [13:0] r, logic sw, logic ps, logic lds, logic junk, int hold);
    send_bits({13'd0, junk, lds, ps, sw, r, 1'b1}, 19);
    model.is_ref = 1'b1;
    model.ratio  = r;
    model.mod64  = sw;
    model.psave  = ~ps;
    model.mon    = lds;
    exp_q.push_back(model);
    pulse_le(hold);
  endtask

  // R4: main word layout bit0=0, swallow 7..1, counter 18..8
  task automatic load_main(logic [6:0] s, logic [10:0] n, int hold);
    send_bits({13'd0, n, s, 1'b0}, 19);
    model.is_ref = 1'b0;
    model.swl    = s;
    model.cnt    = n;
    exp_q.push_back(model);
    pulse_le(hold);
  endtask

  // scoreboard monitor: one queued item for each strobe (R2, R6, R7)
  always @(negedge clk) begin
    if (mon_on && (ref_upd || main_upd)) begin
      chk("R7", "both strobes", int'(ref_upd & main_upd), 0);
      if (exp_q.size() == 0) begin
        total++;
        bad++;
        $display("FAIL R7 unexpected strobe actual=%0d expected=0", ref_upd + main_upd);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R2", "strobe kind ref_upd", ref_upd, int'(e.is_ref));
        cmp_state("R6", e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R7 watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    ser_clk  = 1'b0;
    ser_data = 1'b0;
    ser_le   = 1'b0;
    model    = '{is_ref: 1'b0, ratio: '0, mod64: 1'b0, psave: 1'b1, mon: 1'b0, swl: '0, cnt: '0};
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R8 reset state
    cmp_state("R8", model);
    chk("R8", "ref_upd", ref_upd, 0);
    chk("R8", "main_upd", main_upd, 0);
    mon_on = 1'b1;

    load_ref(14'd6, 1'b1, 1'b1, 1'b0, 1'b0, 3);         // R3 R5 minimum ratio
    load_main(7'd127, 11'd2047, 3);                     // R4 all ones
    load_ref(14'd16383, 1'b0, 1'b0, 1'b1, 1'b1, 3);     // R3 bit 18 set, ignored
    load_main(7'd0, 11'd5, 12);                         // R7 long load strobe
    send_bits(32'h2D, 6);                               // R1 extra leading bits
    load_main(7'h55, 11'h2AA, 3);
    load_ref(14'h1234, 1'b1, 1'b0, 1'b1, 1'b0, 20);     // R7 long hold

    // R9: bits without a load change nothing
    send_bits(32'h7FFFF, 19);
    tick(10);
    cmp_state("R9", model);

    // R7: exact latency, strobe on third edge after ser_le is sampled
    send_bits({13'd0, 11'd100, 7'd3, 1'b0}, 19);
    model.is_ref = 1'b0; model.swl = 7'd3; model.cnt = 11'd100;
    tick(2);
    mon_on = 1'b0;
    ser_le = 1'b1;
    tick(2);
    chk("R7", "early main_upd", main_upd, 0);
    tick(1);
    chk("R7", "main_upd at latency", main_upd, 1);
    cmp_state("R7", model);
    tick(1);
    chk("R7", "main_upd one cycle", main_upd, 0);
    ser_le = 1'b0;
    tick(4);
    mon_on = 1'b1;

    load_ref(14'd7, 1'b0, 1'b1, 1'b0, 1'b0, 3);         // R6 main kept
    tick(10);
    chk("R7", "pending items", exp_q.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule